// File: doc/BRIEF.md
# Constant Divider by Reciprocal Multiplication

This block divides an unsigned 32-bit operand by a fixed divisor without a divide unit. Software (or a bench) works out three constants for the divisor once: a 32-bit scaled reciprocal, a half-step flag and a final shift count. It loads them through a write strobe while the block is idle. Each operand is then multiplied by the reciprocal, corrected and shifted in a three-stage pipeline. One operand can be accepted and one quotient delivered on every cycle.

There are two fast paths. Some divisors need a 33-bit reciprocal. For these only its upper 32 bits are kept, and the dropped half step is restored by adding half of the operand into the low product word. A zero reciprocal marks a power-of-two divisor. The multiplier result is then replaced by the operand itself, so only the shift remains. The remainder is not produced. Only the quotient leaves the block.

Operands enter and quotients leave over valid/ready handshakes. All three stages move together when the output register is free or being drained.

Top module: `recip_div`

## Requirements
- R1: When rst_n is low at a rising edge, all three stage-valid bits clear, so that on the next cycle out_valid reads 0 and in_ready reads 1.
- R2: Reset does not touch the configuration registers. An operand accepted after reset, with no new write, is divided by the divisor configured before the reset.
- R3: With cfg_recip nonzero and cfg_half 0, out_quot equals the upper 32 bits of operand*cfg_recip, shifted right by cfg_shift. For a divisor d that is not a power of two, set l = ceil(log2 d) and m = ceil(2^(32+l)/d), a 33-bit value. Then cfg_recip = m>>1, cfg_half = bit 0 of m and cfg_shift = l-1. With these constants, out_quot equals floor(operand/d) for every 32-bit operand.
- R4: With cfg_half 1 and cfg_recip nonzero, floor(operand/2) is added to the low 32 bits of the product, and the carry out of that addition is added into the high 32 bits before the shift.
- R5: With cfg_recip 0, out_quot equals the operand shifted right by cfg_shift, whatever cfg_half holds. A divisor 2^k uses cfg_shift = k, and a divisor of 1 uses cfg_shift = 0.
- R6: An operand accepted at a rising edge appears on out_valid/out_quot after the third rising edge, counting the accepting edge, provided out_ready is high until then.
- R7: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_quot holds its value. Quotients leave in the order the operands arrived.
- R8: A configuration write (cfg_we high at a rising edge) is ignored while any stage holds a valid operand.
- R9: A configuration write is ignored at an edge where an operand is also accepted. That operand and later ones keep using the previous constants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline valid bits |
| cfg_we | input | 1 | Write strobe for the three constants |
| cfg_recip | input | 32 | Upper 32 bits of the scaled reciprocal; 0 selects the power-of-two path |
| cfg_half | input | 1 | 1 when the dropped reciprocal bit was set (half-operand correction) |
| cfg_shift | input | 5 | Final right shift, 0 to 31 |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand accepted this cycle when in_valid is high |
| in_data | input | 32 | Unsigned dividend |
| out_valid | output | 1 | Quotient present |
| out_ready | input | 1 | Downstream takes the quotient |
| out_quot | output | 32 | Unsigned quotient |

## Verification
The bench builds the block with the package defaults: a 32-bit operand and reciprocal and a 5-bit shift. At these values every divisor from 1 to 2^32-1 can be loaded. The bench computes the constants itself with 128-bit integer arithmetic and checks each quotient against plain integer division. The inputs cover all 32 power-of-two shifts, divisors with the half flag both set and clear, divisors just below 2^32, and the operands 0, 2^32-1, d-1 and d, with random stalls on out_ready.

// File: rtl/recip_div_pkg.sv
// Shared widths and record types for the reciprocal-multiply divider.
// Assumes an unsigned operand; every derived width follows from DIV_W.
package recip_div_pkg;
    localparam int unsigned DIV_W   = 32;
    localparam int unsigned SHIFT_W = $clog2(DIV_W);
    localparam int unsigned PROD_W  = 2 * DIV_W;
    localparam int unsigned STAGES  = 3;

    // The three constants that describe one divisor.
    typedef struct packed {
        logic [DIV_W-1:0]   recip;
        logic               half_en;
        logic [SHIFT_W-1:0] shift;
    } div_cfg_t;
endpackage

// File: rtl/recip_div_cfg.sv
// Holds the divisor constants. A write lands only while the pipeline is
// idle, so every operand in flight sees one consistent set. There is no
// reset: the constants survive a pipeline reset on purpose.
module recip_div_cfg
    import recip_div_pkg::*;
(
    input  logic     clk,
    input  logic     wr_en,
    input  logic     busy,
    input  div_cfg_t wr_cfg,
    output div_cfg_t cfg_q
);
    // Capture a new constant set when requested and nothing is in flight.
    always_ff @(posedge clk) begin
        if (wr_en && !busy) begin
            cfg_q <= wr_cfg;
        end
    end
endmodule

// File: rtl/recip_div_mul.sv
// Stage 1: forms the full product of operand and reciprocal, or for a zero
// reciprocal puts the operand straight into the high word. Also registers
// the half-operand term used by the next stage (zero unless needed).
module recip_div_mul #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         en,
    input  logic [W-1:0] x,
    input  logic [W-1:0] recip,
    input  logic         half_en,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] addend_q
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] prod;
    logic          bypass;

    // Full-width product and power-of-two detection.
    always_comb begin
        prod   = PW'(x) * PW'(recip);
        bypass = (recip == '0);
    end

    // Register the split product and the correction term.
    always_ff @(posedge clk) begin
        if (en) begin
            if (bypass) begin
                hi_q     <= x;
                lo_q     <= '0;
                addend_q <= '0;
            end else begin
                hi_q     <= prod[PW-1:W];
                lo_q     <= prod[W-1:0];
                addend_q <= half_en ? (x >> 1) : '0;
            end
        end
    end
endmodule

// File: rtl/recip_div_fix.sv
// Stage 2: adds the half-operand term into the low word and carries into
// the high word. Assumes the sum never overflows the high word, which
// holds for any 32-bit reciprocal and operand.
module recip_div_fix #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         en,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] addend,
    output logic [W-1:0] hi_q
);
    logic [W:0] low_sum;

    // Low-word addition; only its carry is kept.
    always_comb begin
        low_sum = {1'b0, lo} + {1'b0, addend};
    end

    // Propagate the carry into the high word.
    always_ff @(posedge clk) begin
        if (en) begin
            hi_q <= hi + W'(low_sum[W]);
        end
    end
endmodule

// File: rtl/recip_div_shr.sv
// Stage 3: final logical right shift of the corrected high word.
module recip_div_shr #(
    parameter int unsigned W  = 32,
    parameter int unsigned SW = 5
) (
    input  logic          clk,
    input  logic          en,
    input  logic [W-1:0]  hi,
    input  logic [SW-1:0] shift,
    output logic [W-1:0]  quot_q
);
    // Register the shifted quotient.
    always_ff @(posedge clk) begin
        if (en) begin
            quot_q <= hi >> shift;
        end
    end
endmodule

// File: rtl/recip_div.sv
// Constant divider top. It joins the constant store and the three stages,
// and runs one valid bit per stage. All stages advance together whenever
// the last stage is empty or its quotient is being taken. Assumes the
// constants were worked out for the wanted divisor beforehand.
module recip_div
    import recip_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [DIV_W-1:0]   cfg_recip,
    input  logic               cfg_half,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DIV_W-1:0]   in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DIV_W-1:0]   out_quot
);
    logic [STAGES-1:0] vld;
    logic              advance;
    logic              busy;
    div_cfg_t          cfg_q;
    div_cfg_t          cfg_new;
    logic [DIV_W-1:0]  s1_hi, s1_lo, s1_add;
    logic [DIV_W-1:0]  s2_hi;

    // Global advance and the busy condition that blocks writes.
    always_comb begin
        advance   = !vld[STAGES-1] || out_ready;
        in_ready  = advance;
        out_valid = vld[STAGES-1];
        busy      = (|vld) || (in_valid && advance);
        cfg_new   = '{recip: cfg_recip, half_en: cfg_half, shift: cfg_shift};
    end

    // Stage valid chain, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (advance) begin
            vld <= {vld[STAGES-2:0], in_valid};
        end
    end

    recip_div_cfg u_cfg (
        .clk    (clk),
        .wr_en  (cfg_we),
        .busy   (busy),
        .wr_cfg (cfg_new),
        .cfg_q  (cfg_q)
    );

    recip_div_mul #(.W(DIV_W)) u_mul (
        .clk      (clk),
        .en       (advance),
        .x        (in_data),
        .recip    (cfg_q.recip),
        .half_en  (cfg_q.half_en),
        .hi_q     (s1_hi),
        .lo_q     (s1_lo),
        .addend_q (s1_add)
    );

    recip_div_fix #(.W(DIV_W)) u_fix (
        .clk    (clk),
        .en     (advance),
        .hi     (s1_hi),
        .lo     (s1_lo),
        .addend (s1_add),
        .hi_q   (s2_hi)
    );

    recip_div_shr #(.W(DIV_W), .SW(SHIFT_W)) u_shr (
        .clk    (clk),
        .en     (advance),
        .hi     (s2_hi),
        .shift  (cfg_q.shift),
        .quot_q (out_quot)
    );
endmodule

// File: rtl/recip_div_chk.sv
// Checker for the divider's handshake, latency and constant-store rules,
// bound to every instance of the top module.
module recip_div_chk
    import recip_div_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DIV_W-1:0] out_quot,
    input logic             busy,
    input div_cfg_t         cfg_now
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2
    reset_keeps_cfg_chk: assert property (@(posedge clk)
        (!rst_n && !cfg_we) |=> $stable(cfg_now));

    // R6
    latency_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) &&
         $past(in_valid && in_ready, 3) &&
         $past(out_ready, 1) && $past(out_ready, 2)) |-> out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_quot)));

    // R7
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8
    busy_write_ignored_chk: assert property (@(posedge clk)
        (busy && cfg_we) |=> $stable(cfg_now));

    // R9
    accept_write_ignored_chk: assert property (@(posedge clk)
        (in_valid && in_ready && cfg_we) |=> $stable(cfg_now));
endmodule

bind recip_div recip_div_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_quot  (out_quot),
    .busy      (busy),
    .cfg_now   (cfg_q)
);

// File: tb/recip_div_test.sv
module recip_div_test;
    localparam int CLK_P = 10;

    // {divisor, dividend, quotient}
    localparam logic [95:0] VEC [0:11] = '{
        {32'd1,          32'hDEADBEEF, 32'hDEADBEEF},
        {32'd3,          32'hFFFFFFFF, 32'd1431655765},
        {32'd7,          32'd100,      32'd14},
        {32'd10,         32'd12345,    32'd1234},
        {32'd6,          32'hFFFFFFFF, 32'd715827882},
        {32'd641,        32'hFFFFFFFF, 32'd6700416},
        {32'd16,         32'd255,      32'd15},
        {32'h80000000,   32'hFFFFFFFF, 32'd1},
        {32'hFFFFFFFF,   32'hFFFFFFFF, 32'd1},
        {32'hFFFFFFFF,   32'hFFFFFFFE, 32'd0},
        {32'd1000000,    32'd4000000000, 32'd4000},
        {32'd5,          32'd0,        32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_recip = '0;
    logic        cfg_half = 1'b0;
    logic [4:0]  cfg_shift = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_quot;

    int          checks = 0;
    int          errs = 0;
    bit          finished = 1'b0;
    logic [31:0] stim [0:63];
    logic [31:0] expq [0:63];

    recip_div uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_recip(cfg_recip),
        .cfg_half(cfg_half), .cfg_shift(cfg_shift), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_quot(out_quot)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Constants per requirements R3/R5.
    task automatic make_cfg(input logic [31:0] d, output logic [31:0] r,
                            output logic h, output logic [4:0] s);
        logic [127:0] num;
        logic [127:0] m;
        int l;
        l = 0;
        while ((64'd1 << l) < 64'(d)) l++;
        if ((d & (d - 1)) == 0) begin
            r = '0; h = 1'b0; s = 5'(l);
        end else begin
            num = 128'd1 << (32 + l);
            m = (num + 128'(d) - 128'd1) / 128'(d);
            r = m[32:1]; h = m[0]; s = 5'(l - 1);
        end
    endtask

    function automatic string tag_of(input logic [31:0] d);
        logic [127:0] num;
        logic [127:0] m;
        int l;
        if ((d & (d - 1)) == 0) return "R5";
        l = 0;
        while ((64'd1 << l) < 64'(d)) l++;
        num = 128'd1 << (32 + l);
        m = (num + 128'(d) - 128'd1) / 128'(d);
        return m[0] ? "R4" : "R3";
    endfunction

    task automatic write_raw(input logic [31:0] r, input logic h, input logic [4:0] s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_recip = r; cfg_half = h; cfg_shift = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_div(input logic [31:0] d);
        logic [31:0] r;
        logic h;
        logic [4:0] s;
        make_cfg(d, r, h, s);
        write_raw(r, h, s);
    endtask

    // Stream stim[0..n-1], check quotients against expq in order (R7 order).
    task automatic drive_batch(input int n, input bit bp, input string req);
        int sent;
        int got;
        int cyc;
        sent = 0; got = 0; cyc = 0;
        while (got < n && cyc < 5000) begin
            @(negedge clk);
            out_ready = bp ? ($urandom % 4 != 0) : 1'b1;
            in_valid = (sent < n);
            if (sent < n) in_data = stim[sent];
            #1;
            if (out_valid && out_ready) begin
                chk(out_quot == expq[got], req, out_quot, expq[got]);
                got++;
            end
            if (in_valid && in_ready) sent++;
            cyc++;
        end
        if (got < n) chk(1'b0, req, 32'(got), 32'(n));
        in_valid = 1'b0;
        out_ready = 1'b1;
    endtask

    task automatic collect_one(input logic [31:0] exp, input string req);
        bit seen;
        seen = 1'b0;
        out_ready = 1'b1;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            #1;
            if (out_valid) begin
                chk(out_quot == exp, req, out_quot, exp);
                seen = 1'b1;
            end
        end
        if (!seen) chk(1'b0, req, 32'd0, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errs++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

        // Vector table walk
        for (int i = 0; i < 12; i++) begin
            write_div(VEC[i][95:64]);
            stim[0] = VEC[i][63:32];
            expq[0] = VEC[i][31:0];
            drive_batch(1, 1'b0, tag_of(VEC[i][95:64]));
        end

        // R6: latency of three edges
        write_div(32'd7);
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'd700;
        @(negedge clk);
        in_valid = 1'b0;
        #1 chk(out_valid == 1'b0, "R6 after edge 1", 32'(out_valid), 32'd0);
        @(negedge clk);
        #1 chk(out_valid == 1'b0, "R6 after edge 2", 32'(out_valid), 32'd0);
        @(negedge clk);
        #1 chk(out_valid == 1'b1 && out_quot == 32'd100, "R6 after edge 3", out_quot, 32'd100);
        @(negedge clk);
        #1 chk(out_valid == 1'b0, "R6 drained", 32'(out_valid), 32'd0);

        // R7: stall holds output and blocks input, order kept
        write_div(32'd10);
        out_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 32'(30 + 10 * i);
        end
        @(negedge clk);
        in_data = 32'd60;
        #1;
        chk(in_ready == 1'b0, "R7 in_ready low on stall", 32'(in_ready), 32'd0);
        chk(out_valid && out_quot == 32'd3, "R7 first quotient", out_quot, 32'd3);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1 chk(out_valid && out_quot == 32'd3 && !in_ready, "R7 hold", out_quot, 32'd3);
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            if (i > 0) @(negedge clk);
            #1 chk(out_valid && out_quot == 32'(3 + i), "R7 order", out_quot, 32'(3 + i));
        end
        @(negedge clk);
        #1 chk(out_valid == 1'b0, "R7 empty", 32'(out_valid), 32'd0);

        // R8: write while busy is dropped
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_data = 32'd90;
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we = 1'b1; cfg_recip = 32'hAAAAAAAB; cfg_half = 1'b0; cfg_shift = 5'd1;
        @(negedge clk);
        cfg_we = 1'b0;
        collect_one(32'd9, "R8 in flight");
        stim[0] = 32'd90; expq[0] = 32'd9;
        drive_batch(1, 1'b0, "R8 later operand");

        // R9: write on the accepting edge is dropped
        @(negedge clk);
        cfg_we = 1'b1; cfg_recip = 32'hAAAAAAAB; cfg_half = 1'b0; cfg_shift = 5'd1;
        in_valid = 1'b1; in_data = 32'd90;
        #1 chk(in_ready == 1'b1, "R9 accepted", 32'(in_ready), 32'd1);
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        collect_one(32'd9, "R9 same-edge operand");
        drive_batch(1, 1'b0, "R9 later operand");

        // R1/R2: reset mid-stream, constants kept
        write_div(32'd6);
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'd600;
        @(negedge clk);
        in_data = 32'd1200;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk(out_valid == 1'b0, "R1 mid-stream reset", 32'(out_valid), 32'd0);
        out_ready = 1'b1;
        stim[0] = 32'd600; expq[0] = 32'd100;
        drive_batch(1, 1'b0, "R2 constants kept");

        // R5: zero reciprocal ignores the half flag
        write_raw(32'd0, 1'b1, 5'd3);
        stim[0] = 32'h12345678; expq[0] = 32'h02468ACF;
        drive_batch(1, 1'b0, "R5 bypass with half set");

        // R5: all power-of-two divisors
        for (int k = 0; k < 32; k++) begin
            d = 32'd1 << k;
            write_div(d);
            stim[0] = 32'd0; stim[1] = 32'hFFFFFFFF;
            for (int j = 2; j < 8; j++) stim[j] = $urandom;
            for (int j = 0; j < 8; j++) expq[j] = stim[j] / d;
            drive_batch(8, k[0], "R5");
        end

        // R3/R4: random divisors, boundary and random operands
        for (int i = 0; i < 60; i++) begin
            case (i % 3)
                0: d = $urandom;
                1: d = ($urandom >> ($urandom % 28)) + 32'd3;
                default: d = 32'hFFFFFFFF - ($urandom % 1000);
            endcase
            if (d < 32'd2) d = 32'd7;
            write_div(d);
            stim[0] = 32'd0; stim[1] = 32'hFFFFFFFF; stim[2] = d - 1; stim[3] = d;
            for (int j = 4; j < 14; j++) stim[j] = $urandom;
            for (int j = 0; j < 14; j++) expq[j] = stim[j] / d;
            drive_batch(14, i[0], tag_of(d));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule